// File: doc/BRIEF.md
# AUX Channel Request Controller

This block issues a single request on a display auxiliary channel and collects the answer. Software programs a command nibble, a byte count and a 20-bit target address into registers. For a write it also fills a 16-byte data buffer. It then sets a start bit. The controller serialises a request header onto a byte-wide transmit stream, optionally followed by the write payload. It then waits for a reply on a byte-wide receive stream.

When the reply ends, the controller records the reply code, a 4-bit channel status and sticky reply and error flags. For a read that is acknowledged, it also places the returned bytes into the buffer. A deferred reply can be retried automatically. The number of retries and the pause between attempts are both programmable.

The byte streams stand in for the coded line. The bytes go out one per clock, and the bench plays the remote device.

Top module: `aux_req_ctrl`

## Requirements
- R1: After reset every register reads 0x00, every buffer byte reads 0x00, and `tx_valid` is low.
- R2: A request starts with a header on consecutive cycles with `tx_valid` high. Byte 0 is {command nibble, address[19:16]}, byte 1 is address[15:8] and byte 2 is address[7:0]. Unless address-only, byte 3 is {4'h0, count-1}. `tx_last` marks the final byte of the request. In the command nibble, bit 3 selects native (1) or I2C (0), bit 2 is middle-of-transaction, and bit 0 selects read (1).
- R3: A write that is not address-only sends buffer bytes 0 through count-1 right after byte 3. A read sends only the four header bytes.
- R4: Writing the start register with bit 0 and bit 1 set launches an address-only request. It is three bytes long, with no count byte and no payload.
- R5: The start register bit 0 reads 1 from the cycle after the start write until the reply completes, then reads 0. While busy, writes to the command/count register (0x00), the address registers (0x01 to 0x03), the retry register (0x09), the buffer and buffer-clear are ignored.
- R6: The reply code is `rx_data[7:4]` of the first reply byte: 0x0 ACK, 0x1 NACK, 0x2 native DEFER, 0x8 I2C DEFER. It is stored in register 0x06. Register 0x07 takes 0 for ACK, 1 for NACK, 2 for an unresolved DEFER and 3 for anything else. For an ACKed read, the reply bytes that follow the first are written into the buffer from byte 0.
- R7: Register 0x05 bit 1 (reply seen) is set on completion. Bit 0 (error) is set when the channel status is nonzero. Writing 1 to either bit clears only that bit.
- R8: With retry enabled (register 0x09 bit 7), a DEFER is answered by repeating the same request, up to the count in bits 2:0. Between the final reply byte and the first byte of the next attempt there are exactly interval x `US_CYCLES` clock edges. Bits 4:3 select the interval: code 0 is 600, code 1 is 800, code 2 is 1000 and code 3 is 1800. With retry disabled, a DEFER completes at once.
- R9: Writing register 0x08 with bit 7 set zeroes all 16 buffer bytes.
- R10: Buffer byte i is written and read at word address 0x10+i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| tx_valid | output | 1 | Request byte valid |
| tx_data | output | 8 | Request byte |
| tx_last | output | 1 | Final byte of the request |
| rx_valid | input | 1 | Reply byte valid |
| rx_data | input | 8 | Reply byte |
| rx_last | input | 1 | Final byte of the reply |

## Verification
Header packing is checked against randomly drawn commands, addresses and lengths. A design that swapped the address bytes, or that stored the count instead of count minus one, would show up on the very first random transaction.

The retry pause is measured edge by edge for two interval codes. An off-by-one counter would report 599 or 601. The bench also checks that a retry resends the identical request, and that the retry budget stops after the programmed count, so a design that retried forever or never retried is caught.

Register writes are issued while the controller waits for a reply, which exposes a design that lets them corrupt a live request. The write-one-to-clear bits are cleared separately, so a design that clears both together is exposed.

// File: rtl/aux_req_pkg.sv
package aux_req_pkg;
  localparam int BUF_DEPTH = 16;
  localparam int BUF_IW    = $clog2(BUF_DEPTH);

  typedef enum logic [2:0] {S_IDLE, S_SEND, S_WAIT, S_RECV, S_GAP} seq_state_t;

  localparam logic [3:0] RPL_ACK    = 4'h0;
  localparam logic [3:0] RPL_NACK   = 4'h1;
  localparam logic [3:0] RPL_NDEFER = 4'h2;
  localparam logic [3:0] RPL_IDEFER = 4'h8;

  // Header byte idx (0..3) of an outgoing request
  function automatic logic [7:0] hdr_byte(input logic [1:0] idx, input logic [3:0] cmd,
                                          input logic [19:0] addr,
                                          input logic [BUF_IW-1:0] lenm1);
    case (idx)
      2'd0:    return {cmd, addr[19:16]};
      2'd1:    return addr[15:8];
      2'd2:    return addr[7:0];
      default: return 8'(lenm1);
    endcase
  endfunction

  // Number of bytes a request occupies on the line
  function automatic logic [4:0] tx_total(input logic aonly, input logic is_rd,
                                          input logic [BUF_IW-1:0] lenm1);
    if (aonly)      return 5'd3;
    else if (is_rd) return 5'd4;
    else            return 5'd5 + 5'(lenm1);
  endfunction

  function automatic int unsigned interval_us(input logic [1:0] code);
    case (code)
      2'd0:    return 600;
      2'd1:    return 800;
      2'd2:    return 1000;
      default: return 1800;
    endcase
  endfunction

  function automatic logic is_defer(input logic [3:0] code);
    return (code == RPL_NDEFER) || (code == RPL_IDEFER);
  endfunction

  function automatic logic [3:0] status_of(input logic [3:0] code);
    case (code)
      RPL_ACK:                return 4'd0;
      RPL_NACK:               return 4'd1;
      RPL_NDEFER, RPL_IDEFER: return 4'd2;
      default:                return 4'd3;
    endcase
  endfunction
endpackage

// File: rtl/aux_req_buf.sv
module aux_req_buf
  import aux_req_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              host_we,
  input  logic [BUF_IW-1:0] host_idx,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic              line_we,
  input  logic [BUF_IW-1:0] line_idx,
  input  logic [7:0]        line_wdata,
  input  logic [BUF_IW-1:0] seq_idx,
  output logic [7:0]        seq_rdata
);
  logic [7:0] mem_q [BUF_DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < BUF_DEPTH; i++) begin
      if (!rst_n || clr)                             mem_q[i] <= '0;
      else if (line_we && line_idx == BUF_IW'(i))    mem_q[i] <= line_wdata;
      else if (host_we && host_idx == BUF_IW'(i))    mem_q[i] <= host_wdata;
    end
  end

  assign host_rdata = mem_q[host_idx];
  assign seq_rdata  = mem_q[seq_idx];
endmodule

// File: rtl/aux_req_seq.sv
module aux_req_seq
  import aux_req_pkg::*;
#(
  parameter int US_CYCLES = 125,
  parameter int RETRY_W   = 3
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [3:0]         cmd,
  input  logic [19:0]        addr,
  input  logic [BUF_IW-1:0]  lenm1,
  input  logic               aonly,
  input  logic               retry_en,
  input  logic [RETRY_W-1:0] retry_max,
  input  logic [1:0]         intv_code,
  input  logic [7:0]         buf_rd_data,
  output logic [BUF_IW-1:0]  buf_rd_idx,
  output logic               buf_wr_en,
  output logic [BUF_IW-1:0]  buf_wr_idx,
  output logic [7:0]         buf_wr_data,
  output logic               tx_valid,
  output logic [7:0]         tx_data,
  output logic               tx_last,
  input  logic               rx_valid,
  input  logic [7:0]         rx_data,
  input  logic               rx_last,
  output logic               busy,
  output logic               gap,
  output logic               done,
  output logic [3:0]         done_code,
  output logic [3:0]         done_status
);
  localparam int GAP_MAX = 1800 * US_CYCLES;
  localparam int GAP_W   = $clog2(GAP_MAX + 1);

  seq_state_t         st_q;
  logic [4:0]         idx_q;
  logic [BUF_IW:0]    ridx_q;
  logic [RETRY_W-1:0] tries_q;
  logic [GAP_W-1:0]   gap_q;
  logic [3:0]         rcode_q;
  logic [4:0]         n_tx;
  logic               end_evt, retry_take;
  logic [3:0]         end_code;

  assign n_tx       = tx_total(aonly, cmd[0], lenm1);
  assign tx_valid   = (st_q == S_SEND);
  assign tx_last    = tx_valid && (idx_q == n_tx - 5'd1);
  assign buf_rd_idx = BUF_IW'(idx_q - 5'd4);

  always_comb begin
    if (idx_q < 5'd4) tx_data = hdr_byte(idx_q[1:0], cmd, addr, lenm1);
    else              tx_data = buf_rd_data;
  end

  assign end_evt     = rx_valid && rx_last && (st_q == S_WAIT || st_q == S_RECV);
  assign end_code    = (st_q == S_WAIT) ? rx_data[7:4] : rcode_q;
  assign retry_take  = end_evt && is_defer(end_code) && retry_en && (tries_q < retry_max);
  assign done        = end_evt && !retry_take;
  assign done_code   = end_code;
  assign done_status = status_of(end_code);
  assign busy        = (st_q != S_IDLE);
  assign gap         = (st_q == S_GAP);

  assign buf_wr_en   = (st_q == S_RECV) && rx_valid && (rcode_q == RPL_ACK) && cmd[0] &&
                       !ridx_q[BUF_IW];
  assign buf_wr_idx  = ridx_q[BUF_IW-1:0];
  assign buf_wr_data = rx_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      idx_q   <= '0;
      ridx_q  <= '0;
      tries_q <= '0;
      gap_q   <= '0;
      rcode_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (start) begin
          st_q    <= S_SEND;
          idx_q   <= '0;
          tries_q <= '0;
        end
        S_SEND: begin
          idx_q <= idx_q + 5'd1;
          if (tx_last) st_q <= S_WAIT;
        end
        S_WAIT: if (rx_valid) begin
          rcode_q <= rx_data[7:4];
          ridx_q  <= '0;
          st_q    <= S_RECV;
        end
        S_RECV: if (rx_valid && !ridx_q[BUF_IW]) ridx_q <= ridx_q + 1'b1;
        S_GAP: begin
          if (gap_q == '0) begin
            st_q  <= S_SEND;
            idx_q <= '0;
          end else begin
            gap_q <= gap_q - 1'b1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
      if (end_evt) begin
        if (retry_take) begin
          st_q    <= S_GAP;
          tries_q <= tries_q + 1'b1;
          gap_q   <= GAP_W'(interval_us(intv_code) * US_CYCLES - 1);
        end else begin
          st_q <= S_IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/aux_req_ctrl.sv
module aux_req_ctrl
  import aux_req_pkg::*;
#(
  parameter int US_CYCLES = 125,
  parameter int RETRY_W   = 3
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [5:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       tx_last,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       rx_last
);
  localparam logic [5:0] A_CTL = 6'h00;
  localparam logic [5:0] A_AD0 = 6'h01;
  localparam logic [5:0] A_AD1 = 6'h02;
  localparam logic [5:0] A_AD2 = 6'h03;
  localparam logic [5:0] A_GO  = 6'h04;
  localparam logic [5:0] A_STS = 6'h05;
  localparam logic [5:0] A_RXC = 6'h06;
  localparam logic [5:0] A_CST = 6'h07;
  localparam logic [5:0] A_BUF = 6'h08;
  localparam logic [5:0] A_RTY = 6'h09;

  logic [7:0]         ctl_q;
  logic [19:0]        addr_q;
  logic               aonly_q;
  logic               sts_rpl_q, sts_err_q;
  logic [3:0]         rxcmd_q, chsta_q;
  logic               rty_en_q;
  logic [1:0]         rty_int_q;
  logic [RETRY_W-1:0] rty_cnt_q;

  logic              busy_w, gap_w, done_w;
  logic [3:0]        done_code_w, done_st_w;
  logic              cfg_we, start_w, buf_sel, buf_clr_w, host_buf_we, sts_w1c;
  logic [BUF_IW-1:0] seq_rd_idx, line_wr_idx;
  logic [7:0]        seq_rd_data, host_rd_data, line_wr_data;
  logic              line_we;

  assign cfg_we      = reg_we && !busy_w;
  assign buf_sel     = (reg_addr[5:4] == 2'b01);
  assign start_w     = cfg_we && (reg_addr == A_GO) && reg_wdata[0];
  assign host_buf_we = cfg_we && buf_sel;
  assign buf_clr_w   = cfg_we && (reg_addr == A_BUF) && reg_wdata[7];
  assign sts_w1c     = reg_we && (reg_addr == A_STS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q     <= '0;
      addr_q    <= '0;
      aonly_q   <= 1'b0;
      rty_en_q  <= 1'b0;
      rty_int_q <= '0;
      rty_cnt_q <= '0;
    end else if (cfg_we) begin
      case (reg_addr)
        A_CTL: ctl_q          <= reg_wdata;
        A_AD0: addr_q[7:0]    <= reg_wdata;
        A_AD1: addr_q[15:8]   <= reg_wdata;
        A_AD2: addr_q[19:16]  <= reg_wdata[3:0];
        A_GO:  if (reg_wdata[0]) aonly_q <= reg_wdata[1];
        A_RTY: begin
          rty_en_q  <= reg_wdata[7];
          rty_int_q <= reg_wdata[4:3];
          rty_cnt_q <= reg_wdata[RETRY_W-1:0];
        end
        default: ;
      endcase
    end
  end

  // Completion sets, write-one clears; a set in the same cycle wins
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_rpl_q <= 1'b0;
      sts_err_q <= 1'b0;
      rxcmd_q   <= '0;
      chsta_q   <= '0;
    end else begin
      sts_rpl_q <= done_w | (sts_rpl_q & ~(sts_w1c & reg_wdata[1]));
      sts_err_q <= (done_w && done_st_w != 4'd0) | (sts_err_q & ~(sts_w1c & reg_wdata[0]));
      if (done_w) begin
        rxcmd_q <= done_code_w;
        chsta_q <= done_st_w;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (buf_sel) reg_rdata = host_rd_data;
    else begin
      case (reg_addr)
        A_CTL: reg_rdata = ctl_q;
        A_AD0: reg_rdata = addr_q[7:0];
        A_AD1: reg_rdata = addr_q[15:8];
        A_AD2: reg_rdata = {4'h0, addr_q[19:16]};
        A_GO:  reg_rdata = {6'h0, aonly_q, busy_w};
        A_STS: reg_rdata = {6'h0, sts_rpl_q, sts_err_q};
        A_RXC: reg_rdata = {4'h0, rxcmd_q};
        A_CST: reg_rdata = {4'h0, chsta_q};
        A_RTY: begin
          reg_rdata[7]           = rty_en_q;
          reg_rdata[4:3]         = rty_int_q;
          reg_rdata[RETRY_W-1:0] = rty_cnt_q;
        end
        default: reg_rdata = '0;
      endcase
    end
  end

  aux_req_buf u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (buf_clr_w),
    .host_we    (host_buf_we),
    .host_idx   (reg_addr[BUF_IW-1:0]),
    .host_wdata (reg_wdata),
    .host_rdata (host_rd_data),
    .line_we    (line_we),
    .line_idx   (line_wr_idx),
    .line_wdata (line_wr_data),
    .seq_idx    (seq_rd_idx),
    .seq_rdata  (seq_rd_data)
  );

  aux_req_seq #(.US_CYCLES(US_CYCLES), .RETRY_W(RETRY_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start_w),
    .cmd         (ctl_q[3:0]),
    .addr        (addr_q),
    .lenm1       (ctl_q[7:4]),
    .aonly       (aonly_q),
    .retry_en    (rty_en_q),
    .retry_max   (rty_cnt_q),
    .intv_code   (rty_int_q),
    .buf_rd_data (seq_rd_data),
    .buf_rd_idx  (seq_rd_idx),
    .buf_wr_en   (line_we),
    .buf_wr_idx  (line_wr_idx),
    .buf_wr_data (line_wr_data),
    .tx_valid    (tx_valid),
    .tx_data     (tx_data),
    .tx_last     (tx_last),
    .rx_valid    (rx_valid),
    .rx_data     (rx_data),
    .rx_last     (rx_last),
    .busy        (busy_w),
    .gap         (gap_w),
    .done        (done_w),
    .done_code   (done_code_w),
    .done_status (done_st_w)
  );
endmodule

// File: rtl/aux_req_ctrl_chk.sv
module aux_req_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_valid,
  input logic       tx_last,
  input logic       busy,
  input logic       gap,
  input logic       done,
  input logic [3:0] done_st,
  input logic       rpl_bit,
  input logic       err_bit
);
  a_r5_tx_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> busy);

  a_r2_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  a_r5_idle_follows_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  a_r7_done_sets_reply: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> rpl_bit);

  a_r7_bad_status_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_st != 4'd0) |=> err_bit);

  a_r8_silent_in_gap: assert property (@(posedge clk) disable iff (!rst_n)
    gap |-> !tx_valid);
endmodule

bind aux_req_ctrl aux_req_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_valid (tx_valid),
  .tx_last  (tx_last),
  .busy     (busy_w),
  .gap      (gap_w),
  .done     (done_w),
  .done_st  (done_st_w),
  .rpl_bit  (sts_rpl_q),
  .err_bit  (sts_err_q)
);

// File: tb/aux_req_ctrl_tb.sv
module aux_req_ctrl_tb;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic       tx_valid, tx_last;
  logic [7:0] tx_data;
  logic       rx_valid = 1'b0, rx_last = 1'b0;
  logic [7:0] rx_data = '0;

  int n_chk = 0, n_bad = 0;
  logic [7:0] wmodel [16];
  logic [7:0] rdat [16];
  logic [7:0] cap [20];
  logic [7:0] expb [20];
  int cap_n, exp_n;

  aux_req_ctrl #(.US_CYCLES(1), .RETRY_W(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_last(tx_last), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_last(rx_last));

  always #4 clk = ~clk;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic rdchk(input string req, input logic [5:0] a, input int exp);
    logic [7:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  // Expected request bytes, built from the header rules
  task automatic build_exp(input logic [3:0] cmd, input logic [19:0] a, input int len,
                           input bit aonly);
    exp_n = 0;
    expb[exp_n++] = {cmd, a[19:16]};
    expb[exp_n++] = a[15:8];
    expb[exp_n++] = a[7:0];
    if (!aonly) begin
      expb[exp_n++] = 8'(len - 1);
      if (!cmd[0]) for (int i = 0; i < len; i++) expb[exp_n++] = wmodel[i];
    end
  endtask

  task automatic capture();
    cap_n = 0;
    while (!tx_valid) @(negedge clk);
    forever begin
      cap[cap_n] = tx_data;
      cap_n++;
      if (tx_last || cap_n >= 20) break;
      @(negedge clk);
    end
  endtask

  task automatic cmp_tx(input string req);
    capture();
    chk({req, " byte count"}, cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++) chk({req, " byte"}, cap[i], expb[i]);
  endtask

  task automatic reply(input logic [3:0] code, input int nd);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = {code, 4'h0}; rx_last = (nd == 0);
    for (int i = 0; i < nd; i++) begin
      @(negedge clk);
      rx_data = rdat[i]; rx_last = (i == nd - 1);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  task automatic launch(input logic [3:0] cmd, input logic [19:0] a, input int len,
                        input bit aonly);
    wr(6'h00, aonly ? {4'h0, cmd} : {4'(len - 1), cmd});
    wr(6'h01, a[7:0]);
    wr(6'h02, a[15:8]);
    wr(6'h03, {4'h0, a[19:16]});
    if (!aonly && !cmd[0]) for (int i = 0; i < len; i++) wr(6'(16 + i), wmodel[i]);
    wr(6'h04, {6'h0, aonly, 1'b1});
    build_exp(cmd, a, len, aonly);
  endtask

  task automatic gap_len(input string req, input int exp);
    int k = 0;
    while (!tx_valid && k < 5000) begin k++; @(negedge clk); end
    chk(req, k, exp);
  endtask

  initial begin
    logic [7:0] d;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 10; a++) rdchk("R1 register", 6'(a), 0);
    rdchk("R1 buffer", 6'h1F, 0);
    chk("R1 tx_valid", tx_valid, 0);

    // R10: host buffer access, R9: buffer clear
    for (int i = 0; i < 16; i++) begin wmodel[i] = 8'($urandom); wr(6'(16 + i), wmodel[i]); end
    for (int i = 0; i < 16; i++) rdchk("R10 buffer readback", 6'(16 + i), wmodel[i]);
    wr(6'h08, 8'h80);
    for (int i = 0; i < 16; i++) begin rdchk("R9 cleared byte", 6'(16 + i), 0); wmodel[i] = 8'h00; end

    // R4: address-only request
    launch(4'h4, 20'h00050, 0, 1'b1);
    cmp_tx("R4 address-only");
    reply(4'h0, 0);
    rdchk("R5 enable cleared", 6'h04, 8'h02);
    rdchk("R6 status ack", 6'h07, 0);
    rdchk("R7 reply bit", 6'h05, 8'h02);
    wr(6'h05, 8'h03);

    // R3/R5: native write, writes while busy ignored
    wmodel[0] = 8'hA5; wmodel[1] = 8'h3C;
    launch(4'h8, 20'hABCDE, 2, 1'b0);
    rdchk("R5 enable while busy", 6'h04, 8'h01);
    cmp_tx("R3 write payload");
    wr(6'h00, 8'hFF); wr(6'h10, 8'h00); wr(6'h03, 8'h00);
    rdchk("R5 still busy", 6'h04, 8'h01);
    reply(4'h0, 0);
    rdchk("R5 ctl untouched", 6'h00, 8'h18);
    rdchk("R5 buffer untouched", 6'h10, 8'hA5);
    rdchk("R5 address untouched", 6'h03, 8'h0A);

    // R6/R7: NACK and separate write-one-to-clear
    launch(4'h9, 20'h00100, 4, 1'b0);
    cmp_tx("R2 native read header");
    reply(4'h1, 0);
    rdchk("R6 reply code nack", 6'h06, 1);
    rdchk("R6 status nack", 6'h07, 1);
    rdchk("R7 both bits", 6'h05, 8'h03);
    wr(6'h05, 8'h02);
    rdchk("R7 clear reply only", 6'h05, 8'h01);
    wr(6'h05, 8'h01);
    rdchk("R7 clear error", 6'h05, 8'h00);

    // R8: native DEFER retried, interval code 0
    wr(6'h09, 8'b1000_0010);
    launch(4'h9, 20'h12345, 3, 1'b0);
    cmp_tx("R8 first attempt");
    reply(4'h2, 0);
    gap_len("R8 gap 600", 600);
    cmp_tx("R8 repeated request");
    rdat[0] = 8'h11; rdat[1] = 8'h22; rdat[2] = 8'h33;
    reply(4'h0, 3);
    rdchk("R6 ack code", 6'h06, 0);
    rdchk("R6 ack status", 6'h07, 0);
    rdchk("R7 no error", 6'h05, 8'h02);
    for (int i = 0; i < 3; i++) rdchk("R6 read data", 6'(16 + i), rdat[i]);
    wr(6'h05, 8'h03);

    // R8: I2C DEFER exhausts budget, interval code 3
    wr(6'h09, 8'b1001_1001);
    wmodel[0] = 8'h5A;
    launch(4'h0, 20'h00050, 1, 1'b0);
    cmp_tx("R8 i2c write");
    reply(4'h8, 0);
    gap_len("R8 gap 1800", 1800);
    cmp_tx("R8 i2c repeat");
    reply(4'h8, 0);
    rdchk("R8 exhausted idle", 6'h04, 0);
    rdchk("R6 i2c defer code", 6'h06, 8'h08);
    rdchk("R6 defer status", 6'h07, 2);
    rdchk("R7 defer error", 6'h05, 8'h03);
    wr(6'h05, 8'h03);

    // R8: retry disabled
    wr(6'h09, 8'h02);
    launch(4'h8, 20'h00200, 1, 1'b0);
    cmp_tx("R8 no-retry request");
    reply(4'h2, 0);
    begin
      int seen = 0;
      for (int i = 0; i < 8; i++) begin seen += tx_valid; @(negedge clk); end
      chk("R8 no resend", seen, 0);
    end
    rdchk("R6 native defer code", 6'h06, 8'h02);
    rdchk("R8 retry disabled idle", 6'h04, 0);
    wr(6'h05, 8'h03);

    // R2/R3/R6: random transactions
    for (int t = 0; t < 24; t++) begin
      logic [3:0] cmd;
      logic [19:0] a;
      int len;
      cmd = {1'($urandom), 1'($urandom), 1'b0, 1'($urandom)};
      a   = 20'($urandom);
      len = 1 + int'($urandom % 16);
      if (!cmd[0]) for (int i = 0; i < len; i++) wmodel[i] = 8'($urandom);
      launch(cmd, a, len, 1'b0);
      cmp_tx("R2 random request");
      if (cmd[0]) begin
        for (int i = 0; i < len; i++) rdat[i] = 8'($urandom);
        reply(4'h0, len);
        for (int i = 0; i < len; i++) rdchk("R6 random read data", 6'(16 + i), rdat[i]);
      end else begin
        reply(4'h0, 0);
      end
      rdchk("R7 random status", 6'h05, 8'h02);
      wr(6'h05, 8'h03);
    end

    summary();
    $finish;
  end
endmodule